// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block gathers eight interrupt request lines from peripherals into a request register. It applies a per-line mask and picks the most urgent unmasked request under a fixed order, in which line 0 ranks first and line 7 last. It raises an interrupt to the processor only when that request outranks everything already in service. Each request line is asynchronous. It passes through a two-flop synchronizer before any decision is made on it. Software chooses whether a line requests by a rising edge or by a high level.

The processor answers with a sequence of two acknowledge pulses. The start of the first pulse moves the winning request into the in-service register. During the second pulse the block drives a vector byte. The upper bits of that byte hold a programmable base, and the low three bits hold the number of the winning line. An end-of-service command frees the most urgent in-service level.

A small register port holds the mask, the trigger mode, the vector base and a read selector. The port is controlled by an active-low select, active-low read and write strobes, and one address bit. Through the same port, software reads back the request, in-service and mask registers and the current winning level.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are 0, the trigger mode is edge, the vector base is 0, and irqOut and vecOe are low.
- R2: In level mode, request bit n equals the synchronized line n. It follows the line two clock edges after the line changes.
- R3: In edge mode, request bit n is set three clock edges after a low-to-high change on line n. The bit is dropped if the line falls before it is acknowledged. A line that stays high does not request again after its acknowledge.
- R4: Setting mask bit n removes only line n from arbitration. Lower-ranked unmasked lines can still win.
- R5: Among unmasked pending lines, the lowest-numbered line wins.
- R6: irqOut is high exactly when a winner exists and either nothing is in service or the winner's number is below the lowest-numbered in-service bit.
- R7: At the clock edge that first sees ackN low in a sequence, the winner's in-service bit is set. In edge mode the winner's request bit is also cleared.
- R8: On the second acknowledge pulse, vecOe is high from the edge that sees ackN low until the edge that sees it high. During that window vecData = {base[4:0], number[2:0]}. vecData is 0 whenever vecOe is low.
- R9: If no winner exists at the first pulse, the in-service register is unchanged and the delivered number is 7.
- R10: Writing address 0 with bit7=0 and bit5=1 clears only the lowest-numbered set in-service bit.
- R11: Register writes and reads take effect only when csN is low. rdData is 0 unless both csN and rdN are low. A write with csN high changes nothing.
- R12: Writes to address 1 load the mask. A write to address 0 with bit7=1 sets the level mode from bit6 (1 = level) and the base from bits 4:0. A write to address 0 with bit7=0 sets the read selector from bits 1:0. Reads of address 1 return the mask. Reads of address 0 return, by selector value: 0 the request register, 1 the in-service register, 2 {pending, 4'b0, winner number}, 3 zero.
- R13: The acknowledge sequence works with csN held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 8 | Asynchronous interrupt request lines, line 0 ranked first |
| csN | input | 1 | Active-low register select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe; one write per falling strobe |
| addr | input | 1 | Register address bit |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, 0 when not reading |
| ackN | input | 1 | Active-low interrupt acknowledge from the processor |
| irqOut | output | 1 | Interrupt request to the processor |
| vecOe | output | 1 | Vector byte valid on vecData |
| vecData | output | 8 | Vector byte during the second acknowledge pulse |

## Verification
A level-mode request reaches the request register and irqOut two edges after the input changes. An edge-mode request takes three edges, so the bench waits four before it looks. Register writes, the end-of-service command and the first acknowledge take effect at the single edge inside the strobe, and the bench checks them at the following falling edge. rdData is combinational and is sampled two nanoseconds after the strobes are driven at a falling edge. The vector appears one edge after ackN falls, and the bench reads it at the next falling edge, before releasing ackN.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  // strobes from the control unit to the datapath
  typedef struct packed {
    logic commit;   // first acknowledge pulse begins
    logic eoi;      // end of service command
    logic cfgWr;    // mode and vector base write
    logic selWr;    // read selector write
    logic maskWr;   // mask write
    logic rdEn;     // read enabled
    logic rdAddr;   // read address bit
    logic vecOe;    // second pulse, vector is driven
  } dpCtl_t;
endpackage

// File: rtl/irq_vec_control.sv
module irq_vec_control
  import irq_vec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ackN,
  output dpCtl_t            ctl
);
  localparam int CFG_BIT = DATA_W - 1;
  localparam int EOI_BIT = DATA_W - 3;

  logic wrAct, wrQ, wrStart;
  logic ack, ackQ, ackStart;
  logic waitSecond, vecPhase;

  assign wrAct    = !csN && !wrN;
  assign wrStart  = wrAct && !wrQ;
  assign ack      = !ackN;
  assign ackStart = ack && !ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ        <= 1'b0;
      ackQ       <= 1'b0;
      waitSecond <= 1'b0;
      vecPhase   <= 1'b0;
    end else begin
      wrQ  <= wrAct;
      ackQ <= ack;
      if (ackStart) begin
        waitSecond <= !waitSecond;
        vecPhase   <= waitSecond;
      end else if (!ack) begin
        vecPhase <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.commit = ackStart && !waitSecond;
    ctl.vecOe  = vecPhase;
    ctl.cfgWr  = wrStart && !addr && wrData[CFG_BIT];
    ctl.selWr  = wrStart && !addr && !wrData[CFG_BIT];
    ctl.eoi    = wrStart && !addr && !wrData[CFG_BIT] && wrData[EOI_BIT];
    ctl.maskWr = wrStart && addr;
    ctl.rdEn   = !csN && !rdN;
    ctl.rdAddr = addr;
  end
endmodule

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_vec_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [DATA_W-1:0]    wrData,
  input  dpCtl_t               ctl,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic [DATA_W-1:0]    vecData,
  output logic [NUM_LINES-1:0] irr,
  output logic [NUM_LINES-1:0] isr,
  output logic [NUM_LINES-1:0] maskReg
);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int BASE_W = DATA_W - IDX_W;
  localparam int MODE_BIT = DATA_W - 2;
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(NUM_LINES - 1);

  // lowest-numbered set bit, with a valid flag on top
  function automatic logic [IDX_W:0] firstSet(input logic [NUM_LINES-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  logic [NUM_LINES-1:0] syncA, syncB, syncPrev, reqEdge;
  logic [NUM_LINES-1:0] pend, commitBits, eoiBits;
  logic                 levelMode;
  logic [BASE_W-1:0]    vecBase;
  logic [1:0]           readSel;
  logic [IDX_W-1:0]     vecNum;
  logic [IDX_W:0]       winner, topIsr;
  logic                 winValid, isrValid;
  logic [IDX_W-1:0]     winIdx, isrIdx;
  logic [DATA_W-1:0]    levelByte, selByte;

  assign irr      = levelMode ? syncB : reqEdge;
  assign pend     = irr & ~maskReg;
  assign winner   = firstSet(pend);
  assign topIsr   = firstSet(isr);
  assign winValid = winner[IDX_W];
  assign winIdx   = winner[IDX_W-1:0];
  assign isrValid = topIsr[IDX_W];
  assign isrIdx   = topIsr[IDX_W-1:0];

  assign commitBits = (ctl.commit && winValid) ? (NUM_LINES'(1) << winIdx) : '0;
  assign eoiBits    = (ctl.eoi && isrValid) ? (NUM_LINES'(1) << isrIdx) : '0;

  assign irqOut  = winValid && (!isrValid || (winIdx < isrIdx));
  assign vecData = ctl.vecOe ? {vecBase, vecNum} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      syncPrev  <= '0;
      reqEdge   <= '0;
      isr       <= '0;
      maskReg   <= '0;
      levelMode <= 1'b0;
      vecBase   <= '0;
      readSel   <= '0;
      vecNum    <= '0;
    end else begin
      syncA    <= reqIn;
      syncB    <= syncA;
      syncPrev <= syncB;
      reqEdge  <= (reqEdge | (syncB & ~syncPrev)) & syncB & ~commitBits;
      isr      <= (isr & ~eoiBits) | commitBits;
      if (ctl.commit) vecNum <= winValid ? winIdx : SPUR_IDX;
      if (ctl.maskWr) maskReg <= wrData[NUM_LINES-1:0];
      if (ctl.cfgWr) begin
        levelMode <= wrData[MODE_BIT];
        vecBase   <= wrData[BASE_W-1:0];
      end
      if (ctl.selWr) readSel <= wrData[1:0];
    end
  end

  assign levelByte = {winValid, {(DATA_W-1-IDX_W){1'b0}}, winValid ? winIdx : '0};

  always_comb begin
    case (readSel)
      2'd0:    selByte = DATA_W'(irr);
      2'd1:    selByte = DATA_W'(isr);
      2'd2:    selByte = levelByte;
      default: selByte = '0;
    endcase
    if (!ctl.rdEn)      rdData = '0;
    else if (ctl.rdAddr) rdData = DATA_W'(maskReg);
    else                 rdData = selByte;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 csN,
  input  logic                 rdN,
  input  logic                 wrN,
  input  logic                 addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 ackN,
  output logic                 irqOut,
  output logic                 vecOe,
  output logic [DATA_W-1:0]    vecData
);
  dpCtl_t               ctl;
  logic [NUM_LINES-1:0] irr, isr, maskReg;

  assign vecOe = ctl.vecOe;

  irq_vec_control #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .wrData(wrData), .ackN(ackN), .ctl(ctl)
  );

  irq_vec_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .wrData(wrData), .ctl(ctl),
    .rdData(rdData), .irqOut(irqOut), .vecData(vecData),
    .irr(irr), .isr(isr), .maskReg(maskReg)
  );
endmodule

// File: rtl/irq_vec_checker.sv
module irq_vec_checker #(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 rdN,
  input logic                 ackN,
  input logic                 irqOut,
  input logic                 vecOe,
  input logic [DATA_W-1:0]    vecData,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_LINES-1:0] irr,
  input logic [NUM_LINES-1:0] isr,
  input logic [NUM_LINES-1:0] maskReg
);
  // R6: an interrupt needs an unmasked pending request
  p_irq_needs_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((irr & ~maskReg) != '0));

  // R7: one acknowledge puts at most one level into service
  p_one_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(isr & ~$past(isr)) <= 1);

  // R10: one end-of-service frees at most one level
  p_one_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones($past(isr) & ~isr) <= 1);

  // R8: the vector is driven only inside an acknowledge pulse
  p_vec_in_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    vecOe |-> !$past(ackN));

  // R8: bus quiet outside the vector window
  p_vec_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !vecOe |-> (vecData == '0));

  // R11: no read data without select and read strobe
  p_rd_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> (rdData == '0));
endmodule

bind irq_vec_ctrl irq_vec_checker #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .ackN(ackN),
  .irqOut(irqOut), .vecOe(vecOe), .vecData(vecData), .rdData(rdData),
  .irr(irr), .isr(isr), .maskReg(maskReg)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqIn = '0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1, addr = 1'b0, ackN = 1'b1;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, vecData;
  logic       irqOut, vecOe;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  irq_vec_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .wrData(wrData), .rdData(rdData), .ackN(ackN),
    .irqOut(irqOut), .vecOe(vecOe), .vecData(vecData)
  );

  // {requests, mask, expected irq, expected level byte}; level mode, nothing in service
  localparam logic [31:0] TBL [8] = '{
    32'h00_00_00_00, 32'h01_00_01_80, 32'h81_00_01_80, 32'h81_01_01_87,
    32'hF0_10_01_85, 32'hFF_FF_00_00, 32'h0C_04_01_83, 32'h40_BF_01_86
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cs(input logic sel, input logic a, input logic [7:0] d);
    @(negedge clk);
    csN = sel; wrN = 1'b0; addr = a; wrData = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_cs(1'b0, a, d);
  endtask

  task automatic rd_cs(input logic sel, input logic a, output logic [7:0] v);
    @(negedge clk);
    csN = sel; rdN = 1'b0; addr = a;
    #2 v = rdData;
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    rd_cs(1'b0, a, v);
  endtask

  // first pulse; csN stays high throughout (R13)
  task automatic ack_first();
    @(negedge clk); ackN = 1'b0;
    @(negedge clk); ackN = 1'b1;
  endtask

  task automatic ack_second(input string tag, input logic [7:0] expVec);
    @(negedge clk); ackN = 1'b0;
    @(negedge clk);
    chk({tag, " vecOe"}, {7'd0, vecOe}, 8'h01);
    chk({tag, " vector"}, vecData, expVec);
    ackN = 1'b1;
    @(negedge clk);
    chk({tag, " vecOe after"}, {7'd0, vecOe}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    wait_edges(3);
    rstN = 1'b1;
    wait_edges(1);
    // R1 reset state
    chk("R1 irqOut", {7'd0, irqOut}, 8'h00);
    chk("R1 vecOe", {7'd0, vecOe}, 8'h00);
    rd(1'b0, v); chk("R1 request reg", v, 8'h00);
    rd(1'b1, v); chk("R1 mask reg", v, 8'h00);
    wr(1'b0, 8'h01); rd(1'b0, v); chk("R1 in-service reg", v, 8'h00);

    // R2 R4 R5 R6 R12: level mode table
    wr(1'b0, 8'hC0);           // level mode, base 0
    wr(1'b0, 8'h02);           // select level byte
    for (int i = 0; i < 8; i++) begin
      wr(1'b1, TBL[i][23:16]);
      reqIn = TBL[i][31:24];
      wait_edges(3);
      chk($sformatf("R4 R5 R6 row %0d irq", i), {7'd0, irqOut}, TBL[i][15:8]);
      rd(1'b0, v);
      chk($sformatf("R5 R12 row %0d level", i), v, TBL[i][7:0]);
    end
    reqIn = 8'h00;
    wr(1'b1, 8'h00);
    wait_edges(3);
    // R2 level request follows the line, two edges
    wr(1'b0, 8'h00);
    @(negedge clk); reqIn = 8'h08;
    wait_edges(2);
    rd(1'b0, v); chk("R2 level request", v, 8'h08);
    reqIn = 8'h00;
    wait_edges(3);
    rd(1'b0, v); chk("R2 level drop", v, 8'h00);

    // edge mode, base 0x15
    wr(1'b0, 8'h95);
    wait_edges(3);
    reqIn = 8'h04;
    wait_edges(4);
    chk("R3 edge irq", {7'd0, irqOut}, 8'h01);
    rd(1'b0, v); chk("R3 edge request", v, 8'h04);
    ack_first();
    wait_edges(1);
    chk("R7 irq after commit", {7'd0, irqOut}, 8'h00);
    rd(1'b0, v); chk("R7 request cleared", v, 8'h00);
    wr(1'b0, 8'h01); rd(1'b0, v); chk("R7 in-service set", v, 8'h04);
    ack_second("R8 R13 line2", 8'hAA);
    wait_edges(3);
    wr(1'b0, 8'h00); rd(1'b0, v); chk("R3 no retrigger", v, 8'h00);

    reqIn = 8'h24;
    wait_edges(4);
    chk("R6 lower blocked", {7'd0, irqOut}, 8'h00);
    reqIn = 8'h26;
    wait_edges(4);
    chk("R6 higher passes", {7'd0, irqOut}, 8'h01);
    ack_first();
    ack_second("R8 line1", 8'hA9);
    wr(1'b0, 8'h01); rd(1'b0, v); chk("R7 nested service", v, 8'h06);
    wr(1'b0, 8'h21); rd(1'b0, v); chk("R10 first eoi", v, 8'h04);
    chk("R6 still blocked", {7'd0, irqOut}, 8'h00);
    wr(1'b0, 8'h21); rd(1'b0, v); chk("R10 second eoi", v, 8'h00);
    wait_edges(1);
    chk("R6 line5 released", {7'd0, irqOut}, 8'h01);
    ack_first();
    ack_second("R8 line5", 8'hAD);
    reqIn = 8'h00;
    wr(1'b0, 8'h21);
    wait_edges(3);
    ack_first();
    ack_second("R9 spurious", 8'hAF);
    wr(1'b0, 8'h01); rd(1'b0, v); chk("R9 in-service unchanged", v, 8'h00);

    // R3 line falls before acknowledge
    reqIn = 8'h10;
    wait_edges(4);
    chk("R3 pulse irq", {7'd0, irqOut}, 8'h01);
    reqIn = 8'h00;
    wait_edges(4);
    chk("R3 dropped irq", {7'd0, irqOut}, 8'h00);
    wr(1'b0, 8'h00); rd(1'b0, v); chk("R3 dropped request", v, 8'h00);

    // R11 select gating, R12 mask readback and selector 3
    wr(1'b1, 8'h5A);
    rd(1'b1, v); chk("R12 mask read", v, 8'h5A);
    wr_cs(1'b1, 1'b1, 8'hFF);
    rd(1'b1, v); chk("R11 write ignored", v, 8'h5A);
    rd_cs(1'b1, 1'b1, v); chk("R11 read unselected", v, 8'h00);
    wr(1'b0, 8'h03); rd(1'b0, v); chk("R12 selector 3", v, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule